// File: doc/BRIEF.md
# T1/J1 Superframe Framing-Bit Inserter

This block sits in the transmit path of a T1 or J1 line interface. It takes a serial bit stream, one bit per beat, and writes framing overhead into it for the 12-frame superframe format. Each frame is 193 bits long: a framing bit (F-bit) first, then 24 channels of 8 bits. Internal counters track where each incoming bit falls in the superframe. The block replaces F-bits with the alignment pattern and adds the yellow alarm. On request it also corrupts a single F-bit for test purposes, and in mimic mode it copies each F-bit into the bit that follows it.

Both stream sides use valid/ready handshakes. The output side is a one-entry register. A beat moves from input to output only when `s_valid` and `s_ready` are both high. `s_ready` is high when the output register is empty or is being drained in the same cycle. When `m_valid` is high and `m_ready` is low, the output beat and its sync flags stay frozen and no input is accepted. The frame position therefore advances only on accepted beats, and upstream stalls never shift the framing. Control pins are plain levels, apart from the two error-request pins, which are sampled as one-cycle requests.

Top module: `t1sf_framer`

## Requirements
- R1: A beat accepted on a clock edge appears on `m_data` with `m_valid` high after exactly that edge. `s_ready` equals `!m_valid || m_ready`. While `m_valid && !m_ready`, the output beat and both sync flags hold steady.
- R2: After reset, the first accepted beat is the F-bit of frame 1. Stream position 0 of each 193-beat frame is its F-bit. With framing enabled in T1 mode, the F-bits of frames 1..12 are 1,0,0,0,1,1,0,1,1,1,0,0.
- R3: In J1 mode, frames 1..11 use the same F-bit values as T1. The F-bit of frame 12 is 0 with no yellow alarm and 1 while yellow is active.
- R4: In T1 mode with yellow active and framing enabled, channel bit 2 of every channel (stream positions 2, 10, ..., 186) is sent as 0. In J1 mode these positions pass through unchanged.
- R5: Yellow is active when `cfg_yel_man` is 1, or when both `cfg_yel_auto` and `rx_red` are 1. `rx_red` alone has no effect.
- R6: A one-cycle pulse on `inj_ft` inverts exactly one F-bit: the next odd-numbered frame's F-bit that is accepted with framing enabled. Later odd F-bits are unaffected until another pulse arrives.
- R7: A pulse on `inj_fs` does the same for the next even-numbered frame's F-bit.
- R8: With framing and `cfg_mimic` enabled, stream position 1 carries the F-bit value most recently sent at position 0.
- R9: With `cfg_frm_dis` set, every beat passes through unchanged. No pattern, yellow, mimic or inversion is applied. Pending error requests are kept, and are used once framing is enabled again.
- R10: `m_fsync` is high exactly on output beats that are F-bits. `m_sfsync` is high exactly on the F-bit of frame 1.
- R11: All other beats leave `m_data` equal to the accepted `s_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be accepted |
| s_data | input | 1 | Input serial bit |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts output beat |
| m_data | output | 1 | Output serial bit |
| m_fsync | output | 1 | Output beat is an F-bit |
| m_sfsync | output | 1 | Output beat is the F-bit of frame 1 |
| cfg_frm_dis | input | 1 | Disable all overhead insertion |
| cfg_j1 | input | 1 | 1 selects J1, 0 selects T1 |
| inj_ft | input | 1 | Request one odd-frame F-bit error |
| inj_fs | input | 1 | Request one even-frame F-bit error |
| cfg_mimic | input | 1 | Copy each F-bit into the following bit |
| cfg_yel_man | input | 1 | Send yellow alarm |
| cfg_yel_auto | input | 1 | Send yellow while receive red is present |
| rx_red | input | 1 | Receive red alarm declared |

## Verification
If the position counters slip by even one beat, the F-bits leave their slots. The first misplaced F-bit, or a `m_fsync` on the wrong beat, shows up at the output within one frame of 193 accepted beats. A wrong frame index shows up as a pattern error within one superframe. An error request that is never cleared, or one that is lost, makes extra or missing inverted F-bits appear within two frames of the pulse. A stall-handling fault shows up on the next stalled cycle as a changed or duplicated output beat.

// File: rtl/t1sf_pkg.sv
package t1sf_pkg;
  // Role of the current beat inside a frame
  typedef enum logic [1:0] {
    SLOT_FRAMING = 2'd0,
    SLOT_MIMIC   = 2'd1,
    SLOT_ALARM   = 2'd2,
    SLOT_PAYLOAD = 2'd3
  } slot_e;

  localparam int ERR_KINDS = 2;  // 0: odd-frame F-bit, 1: even-frame F-bit
endpackage

// File: rtl/t1sf_slot_counter.sv
module t1sf_slot_counter
  import t1sf_pkg::*;
#(
  parameter int CHANNELS = 24,
  parameter int CH_BITS  = 8,
  parameter int FRAMES   = 12,
  parameter int YEL_BIT  = 1,
  localparam int FRM_W   = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [FRM_W-1:0] frame_idx,
  output slot_e            slot,
  output logic             first_frame
);
  localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int CB_W       = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;

  logic [BIT_W-1:0] bit_idx;
  logic [CB_W-1:0]  ch_bit;
  logic             at_frame_end;
  logic             at_sf_end;

  assign at_frame_end = (bit_idx == BIT_W'(FRAME_BITS - 1));
  assign at_sf_end    = (frame_idx == FRM_W'(FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      frame_idx <= '0;
      ch_bit    <= '0;
    end else if (adv) begin
      if (at_frame_end) begin
        bit_idx   <= '0;
        frame_idx <= at_sf_end ? '0 : frame_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
      if (bit_idx == '0)
        ch_bit <= '0;
      else if (ch_bit == CB_W'(CH_BITS - 1))
        ch_bit <= '0;
      else
        ch_bit <= ch_bit + 1'b1;
    end
  end

  always_comb begin
    if (bit_idx == '0)
      slot = SLOT_FRAMING;
    else if (bit_idx == BIT_W'(1))
      slot = SLOT_MIMIC;
    else if (ch_bit == CB_W'(YEL_BIT))
      slot = SLOT_ALARM;
    else
      slot = SLOT_PAYLOAD;
  end

  assign first_frame = (frame_idx == '0);
endmodule

// File: rtl/t1sf_fbit_sel.sv
module t1sf_fbit_sel #(
  parameter int               FRAMES = 12,
  parameter logic [FRAMES-1:0] FAS   = 12'b100011011100,
  localparam int              FRM_W  = $clog2(FRAMES)
) (
  input  logic [FRM_W-1:0] frame_idx,
  input  logic             j1_mode,
  input  logic             yellow,
  output logic             fbit
);
  logic [FRAMES-1:0] pat_by_frame;

  // Reverse so that frame index 0 selects the leftmost pattern bit
  for (genvar g = 0; g < FRAMES; g++) begin : g_rev
    assign pat_by_frame[g] = FAS[FRAMES-1-g];
  end

  always_comb begin
    if (j1_mode && frame_idx == FRM_W'(FRAMES - 1))
      fbit = yellow;
    else
      fbit = pat_by_frame[frame_idx];
  end
endmodule

// File: rtl/t1sf_err_arm.sv
module t1sf_err_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic hit,
  output logic fire
);
  logic armed;

  assign fire = armed & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= (armed & ~hit) | req;
  end
endmodule

// File: rtl/t1sf_framer.sv
module t1sf_framer
  import t1sf_pkg::*;
#(
  parameter int               CHANNELS = 24,
  parameter int               CH_BITS  = 8,
  parameter int               FRAMES   = 12,
  parameter int               YEL_BIT  = 1,
  parameter logic [FRAMES-1:0] FAS     = 12'b100011011100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_data,
  output logic m_valid,
  input  logic m_ready,
  output logic m_data,
  output logic m_fsync,
  output logic m_sfsync,
  input  logic cfg_frm_dis,
  input  logic cfg_j1,
  input  logic inj_ft,
  input  logic inj_fs,
  input  logic cfg_mimic,
  input  logic cfg_yel_man,
  input  logic cfg_yel_auto,
  input  logic rx_red
);
  localparam int FRM_W = $clog2(FRAMES);

  logic             accept;
  logic             fr_en;
  logic             yel_active;
  logic [FRM_W-1:0] frame_idx;
  slot_e            slot;
  logic             first_frame;
  logic             fbit_nom;
  logic             fbit_tx;
  logic             last_f;
  logic             bit_out;
  logic             yel_slot;
  logic [ERR_KINDS-1:0] err_req;
  logic [ERR_KINDS-1:0] err_hit;
  logic [ERR_KINDS-1:0] err_fire;

  assign s_ready    = ~m_valid | m_ready;
  assign accept     = s_valid & s_ready;
  assign fr_en      = ~cfg_frm_dis;
  assign yel_active = cfg_yel_man | (cfg_yel_auto & rx_red);
  assign yel_slot   = (slot == SLOT_ALARM);

  t1sf_slot_counter #(
    .CHANNELS(CHANNELS), .CH_BITS(CH_BITS), .FRAMES(FRAMES), .YEL_BIT(YEL_BIT)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(accept),
    .frame_idx(frame_idx), .slot(slot), .first_frame(first_frame)
  );

  t1sf_fbit_sel #(.FRAMES(FRAMES), .FAS(FAS)) u_fsel (
    .frame_idx(frame_idx), .j1_mode(cfg_j1), .yellow(yel_active), .fbit(fbit_nom)
  );

  assign err_req = {inj_fs, inj_ft};

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
    // kind 0 hits odd frames (even index), kind 1 hits even frames
    assign err_hit[k] = accept & fr_en & (slot == SLOT_FRAMING) &
                        (frame_idx[0] == 1'(k));
    t1sf_err_arm u_arm (
      .clk(clk), .rst_n(rst_n), .req(err_req[k]), .hit(err_hit[k]), .fire(err_fire[k])
    );
  end

  assign fbit_tx = fbit_nom ^ (|err_fire);

  always_comb begin
    bit_out = s_data;
    if (fr_en) begin
      unique case (slot)
        SLOT_FRAMING: bit_out = fbit_tx;
        SLOT_MIMIC:   bit_out = cfg_mimic ? last_f : s_data;
        SLOT_ALARM:   bit_out = (yel_active && !cfg_j1) ? 1'b0 : s_data;
        default:      bit_out = s_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= 1'b0;
      m_fsync  <= 1'b0;
      m_sfsync <= 1'b0;
      last_f   <= 1'b0;
    end else begin
      m_valid <= accept | (m_valid & ~m_ready);
      if (accept) begin
        m_data   <= bit_out;
        m_fsync  <= (slot == SLOT_FRAMING);
        m_sfsync <= (slot == SLOT_FRAMING) & first_frame;
        if (slot == SLOT_FRAMING) last_f <= bit_out;
      end
    end
  end
endmodule

// File: rtl/t1sf_framer_chk.sv
module t1sf_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic s_data,
  input logic m_valid,
  input logic m_ready,
  input logic m_data,
  input logic m_fsync,
  input logic m_sfsync,
  input logic cfg_frm_dis,
  input logic cfg_j1,
  input logic yel_active,
  input logic yel_slot
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_fsync) && $stable(m_sfsync)));

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  // R10
  sf_implies_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_sfsync) |-> m_fsync);

  // R9
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && cfg_frm_dis) |=> (m_data == $past(s_data)));

  // R4
  t1_yellow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !cfg_frm_dis && !cfg_j1 && yel_active && yel_slot) |=> !m_data);
endmodule

bind t1sf_framer t1sf_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_fsync(m_fsync),
  .m_sfsync(m_sfsync), .cfg_frm_dis(cfg_frm_dis), .cfg_j1(cfg_j1),
  .yel_active(yel_active), .yel_slot(yel_slot)
);

// File: tb/t1sf_framer_test.sv
module t1sf_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_data = 1'b0, m_ready = 1'b0;
  logic s_ready, m_valid, m_data, m_fsync, m_sfsync;
  logic cfg_frm_dis = 1'b0, cfg_j1 = 1'b0, inj_ft = 1'b0, inj_fs = 1'b0;
  logic cfg_mimic = 1'b0, cfg_yel_man = 1'b0, cfg_yel_auto = 1'b0, rx_red = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  t1sf_framer uut (.*);

  typedef struct { bit d; bit fs; bit sfs; string tag; } exp_t;
  exp_t q[$];

  int vectors = 0, errors = 0;
  int bpos = 0, fr = 0;
  bit pend_ft = 0, pend_fs = 0, lastf = 0;
  bit done = 0;
  int v_pct = 100, r_pct = 100, cfg_churn = 0;
  bit req_ft = 0, req_fs = 0;
  localparam bit [11:0] PAT = 12'b100011011100;

  task automatic chk(bit act, bit exp, string tag, string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at t=%0t: got %0b expected %0b", tag, what, $time, act, exp);
    end
  endtask

  function automatic exp_t model(bit d);
    exp_t e;
    bit yel = cfg_yel_man || (cfg_yel_auto && rx_red);
    string ytag = (!cfg_yel_man && yel) ? "R5" : "R4";
    e.fs = (bpos == 0); e.sfs = (bpos == 0 && fr == 0); e.d = d; e.tag = "R11";
    if (cfg_frm_dis) begin
      e.tag = "R9";
      if (bpos == 0) lastf = d;
    end else if (bpos == 0) begin
      bit f;
      bit odd = (fr % 2 == 0);
      if (cfg_j1 && fr == 11) begin f = yel; e.tag = yel ? ytag : "R3"; end
      else begin f = PAT[11-fr]; e.tag = cfg_j1 ? "R3" : "R2"; end
      if (odd && pend_ft) begin f = !f; pend_ft = 0; e.tag = "R6"; end
      else if (!odd && pend_fs) begin f = !f; pend_fs = 0; e.tag = "R7"; end
      e.d = f; lastf = f;
    end else if (bpos == 1 && cfg_mimic) begin
      e.d = lastf; e.tag = "R8";
    end else if (bpos != 1 && (bpos - 1) % 8 == 1 && yel && !cfg_j1) begin
      e.d = 0; e.tag = ytag;
    end
    bpos++;
    if (bpos == 193) begin bpos = 0; fr = (fr + 1) % 12; end
    return e;
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      // outputs of the last edge
      chk(m_valid, q.size() != 0, "R1", "m_valid");
      if (m_valid && q.size() != 0) begin
        chk(m_data, q[0].d, q[0].tag, "m_data");
        chk(m_fsync, q[0].fs, "R10", "m_fsync");
        chk(m_sfsync, q[0].sfs, "R10", "m_sfsync");
      end
      // new stimulus
      s_valid = ($urandom_range(99) < v_pct);
      m_ready = ($urandom_range(99) < r_pct);
      s_data  = $urandom_range(1);
      inj_ft = req_ft; inj_fs = req_fs; req_ft = 0; req_fs = 0;
      if (cfg_churn != 0 && $urandom_range(999) < cfg_churn) begin
        cfg_j1 = $urandom_range(1); cfg_mimic = $urandom_range(1);
        cfg_yel_man = $urandom_range(1); cfg_yel_auto = $urandom_range(1);
        rx_red = $urandom_range(1); cfg_frm_dis = ($urandom_range(7) == 0);
      end
      if (cfg_churn != 0 && $urandom_range(299) == 0) inj_ft = 1;
      if (cfg_churn != 0 && $urandom_range(299) == 0) inj_fs = 1;
      #1;
      chk(s_ready, !m_valid || m_ready, "R1", "s_ready");
      if (m_valid && m_ready) void'(q.pop_front());
      if (s_valid && s_ready) q.push_back(model(s_data));
      if (inj_ft) pend_ft = 1;
      if (inj_fs) pend_fs = 1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(m_valid, 1'b0, "R1", "reset m_valid");
    chk(s_ready, 1'b1, "R1", "reset s_ready");
    rst_n = 1'b1;
    // R2: T1 pattern, full flow
    step(2 * 2316);
    // R6 / R7: single error requests
    req_ft = 1; step(400);
    req_fs = 1; step(600);
    req_ft = 1; step(1); req_fs = 1; step(1000);
    // R8: mimic
    cfg_mimic = 1; step(2316); cfg_mimic = 0;
    // R4: manual yellow in T1
    cfg_yel_man = 1; step(2316); cfg_yel_man = 0;
    // R5: red alone has no effect, then auto yellow
    rx_red = 1; step(2316);
    cfg_yel_auto = 1; step(2316);
    // R3: J1 with auto yellow, then without
    cfg_j1 = 1; step(2316);
    cfg_yel_auto = 0; rx_red = 0; step(2316);
    // R9: transparent, requests held pending
    cfg_frm_dis = 1; req_ft = 1; step(1); req_fs = 1; step(2316);
    cfg_frm_dis = 0; step(600);
    cfg_j1 = 0;
    // R1: back-pressure with random config churn
    v_pct = 70; r_pct = 60; cfg_churn = 3;
    step(6 * 2316);
    v_pct = 100; r_pct = 100; cfg_churn = 0; cfg_frm_dis = 0;
    step(50);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule